// File: doc/BRIEF.md
# Sleep-State and Power-Restore Controller

This block holds the power-sequencing control of a small I/O controller. It stores a handful of control bits behind a byte-wide register port. It records when standby power comes back, and it decides whether the main power-on output comes up after that event. The choice is set by a restore policy: return to the previous state, force on, or force off. While standby power stays present, the block remembers whether main power was on. That memory survives a standby outage, so the "previous state" policy has something to restore.

Software can request the S1 sleep state through a sleep bit. A power-button wake clears this bit by itself. Any other wake leaves the bit set until software writes 0 to it. The block has three steering controls. The first chooses what drives the S3 indication. The second chooses what drives the reset output. The third sets whether keyboard and mouse wake events reach the power-button output. Four sticky event flags, one per peripheral, record power-management events until software clears them.

Top module: `pwr_restore_ctrl`

## Requirements
- R1: After reset, the control byte (address 0) reads 0x18: policy 11 (off), sleep bit 0, both wake enables 0, loss flag 0. Address 1, address 2 and `pwr_on_o` read 0.
- R2: When `sb_ok_i` rises, the register update that samples the rise sets `pwr_on_o` from the policy field, control byte bits [4:3]. The field's value before that edge is used. 00 restores the stored last state. 10 and 01 force on. 11 forces off.
- R3: The last state is the value of `pwr_on_o` at the final clock edge at which standby was present on both this cycle and the previous one. At every edge where `sb_ok_i` is low, `pwr_on_o` becomes 0.
- R4: The loss flag (control byte bit 7) is set on every rising edge of `sb_ok_i`. A write of 1 to bit 7 clears it and a write of 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R5: Writing control byte bit 0 loads the sleep bit, and `s1_o` shows it. Any cycle with `pwr_btn_o` high clears the bit, even when a write of 1 occurs in the same cycle. Otherwise the bit holds.
- R6: Address 1 bit 0 selects the S3 source. When it is 1, `s3_o` equals the sleep bit. When it is 0, `s3_o` = `s3_pin_i | ~vdd_ok_i`.
- R7: Address 1 bit 1 selects the reset source. When it is 0, `rst_con_o` follows `pwrok_i`. When it is 1, `rst_con_o` follows `pci_rst_n_i`.
- R8: `pwr_btn_o` = `btn_i` OR (`kb_wake_i` AND control bit 1) OR (`ms_wake_i` AND control bit 2).
- R9: Address 2 bits [3:0] are sticky event flags, set by `pme_evt_i[3:0]` (parallel, UART 2, UART 1, floppy). A write of 1 clears a bit and a write of 0 has no effect. If a set and a clear hit the same bit in the same cycle, the set wins.
- R10: With standby present in this cycle and the last one, a cycle with `pwr_btn_o` high sets `pwr_on_o` at the next edge. Without such a cycle, `pwr_on_o` holds.
- R11: `rdata_o` is combinational on `addr_i`. Address 0 reads {loss, 0, 0, policy[1:0], mouse en, kbd en, sleep}. Address 1 reads {000000, reset sel, S3 sel}. Address 2 reads {0000, flags}. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the always-on register domain |
| sb_ok_i | input | 1 | Standby power present |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pme_evt_i | input | 4 | Peripheral PME event pulses |
| btn_i | input | 1 | Power-button press |
| kb_wake_i | input | 1 | Keyboard wake event |
| ms_wake_i | input | 1 | Mouse wake event |
| s3_pin_i | input | 1 | External S3 request |
| vdd_ok_i | input | 1 | Main-supply power-good detect |
| pwrok_i | input | 1 | Power-good input for the reset output |
| pci_rst_n_i | input | 1 | Bus reset input for the reset output |
| pwr_on_o | output | 1 | Registered main power-on output |
| s1_o | output | 1 | Sleep bit (S1 requested) |
| s3_o | output | 1 | S3 indication |
| rst_con_o | output | 1 | Selected reset output |
| pwr_btn_o | output | 1 | Gated power-button/wake output |

## Verification
Two pairs of functions can act on the same bit in the same cycle. A software write-1 clear can meet its own set event, either a standby rise for the loss flag or a peripheral event for a sticky flag. A software write of 1 to the sleep bit can meet a power-button wake. Directed cycles line each pair up on purpose. In addition, the random phase lets standby toggles, wake pulses and writes to all three addresses overlap. A bench reference model computes the expected value under the stated priorities: set over clear, and wake over sleep request. The register readback and `pwr_on_o` are then compared against that model every cycle.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned PME_W  = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_SEL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_PME  = 2'd2;

  // control byte field positions
  localparam int unsigned B_SLEEP = 0;
  localparam int unsigned B_KBEN  = 1;
  localparam int unsigned B_MSEN  = 2;
  localparam int unsigned B_POL   = 3;
  localparam int unsigned B_LOSS  = 7;
  // select byte field positions
  localparam int unsigned B_S3SEL = 0;
  localparam int unsigned B_RSSEL = 1;

  typedef enum logic [1:0] {
    POL_KEEP  = 2'b00,
    POL_ONRSV = 2'b01,
    POL_ON    = 2'b10,
    POL_OFF   = 2'b11
  } restore_pol_e;
endpackage

// File: rtl/w1c_bank.sv
module w1c_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;

  for (genvar k = 0; k < W; k++) begin : g_bit
    always_comb begin
      flag_d[k] = flag_q[k];
      if (clr_wr_i && clr_mask_i[k]) flag_d[k] = 1'b0;
      if (set_i[k])                  flag_d[k] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[k] <= 1'b0;
      else        flag_q[k] <= flag_d[k];
    end
  end

  assign flags_o = flag_q;

  // R4 / R9: a set event always leaves the flag high, whatever the write did
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  // R9: a write of 0 never clears, only a write-1 can take a flag down
  p_clear_only_by_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/restore_unit.sv
module restore_unit
  import pwr_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sb_ok_i,
  input  restore_pol_e policy_i,
  input  logic         wake_i,
  output logic         sb_rise_o,
  output logic         pwr_on_o
);
  logic sb_q;
  logic last_q, last_d;
  logic on_q, on_d;
  logic steady;

  assign sb_rise_o = sb_ok_i && !sb_q;
  assign steady    = sb_ok_i && sb_q;

  always_comb begin
    on_d = on_q;
    if (!sb_ok_i) begin
      on_d = 1'b0;
    end else if (sb_rise_o) begin
      unique case (policy_i)
        POL_KEEP:  on_d = last_q;
        POL_OFF:   on_d = 1'b0;
        default:   on_d = 1'b1;   // forced on, and the reserved alias
      endcase
    end else if (wake_i) begin
      on_d = 1'b1;
    end
  end

  always_comb begin
    last_d = last_q;
    if (steady) last_d = on_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_q   <= 1'b0;
      last_q <= 1'b0;
      on_q   <= 1'b0;
    end else begin
      sb_q   <= sb_ok_i;
      last_q <= last_d;
      on_q   <= on_d;
    end
  end

  assign pwr_on_o = on_q;

  p_off_without_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_ok_i |=> !on_q);

  p_restore_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_rise_o && policy_i == POL_OFF) |=> !on_q);

  p_restore_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_rise_o && policy_i[1] != policy_i[0]) |=> on_q);

  p_wake_turns_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && wake_i) |=> on_q);
endmodule

// File: rtl/pwr_restore_ctrl.sv
module pwr_restore_ctrl
  import pwr_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sb_ok_i,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [3:0]  pme_evt_i,
  input  logic        btn_i,
  input  logic        kb_wake_i,
  input  logic        ms_wake_i,
  input  logic        s3_pin_i,
  input  logic        vdd_ok_i,
  input  logic        pwrok_i,
  input  logic        pci_rst_n_i,
  output logic        pwr_on_o,
  output logic        s1_o,
  output logic        s3_o,
  output logic        rst_con_o,
  output logic        pwr_btn_o
);
  logic         wr_ctrl, wr_sel, wr_pme;
  logic         sleep_q, sleep_d;
  logic         kb_en_q, kb_en_d;
  logic         ms_en_q, ms_en_d;
  restore_pol_e pol_q, pol_d;
  logic         s3sel_q, s3sel_d;
  logic         rssel_q, rssel_d;
  logic         sb_rise;
  logic [0:0]   loss_flag;
  logic [PME_W-1:0] pme_flags;
  logic         unused_wdata;

  assign wr_ctrl = wr_en_i && (addr_i == ADR_CTRL);
  assign wr_sel  = wr_en_i && (addr_i == ADR_SEL);
  assign wr_pme  = wr_en_i && (addr_i == ADR_PME);

  assign pwr_btn_o = btn_i | (kb_wake_i & kb_en_q) | (ms_wake_i & ms_en_q);

  always_comb begin
    sleep_d = sleep_q;
    kb_en_d = kb_en_q;
    ms_en_d = ms_en_q;
    pol_d   = pol_q;
    s3sel_d = s3sel_q;
    rssel_d = rssel_q;
    if (wr_ctrl) begin
      sleep_d = wdata_i[B_SLEEP];
      kb_en_d = wdata_i[B_KBEN];
      ms_en_d = wdata_i[B_MSEN];
      pol_d   = restore_pol_e'(wdata_i[B_POL +: 2]);
    end
    if (pwr_btn_o) sleep_d = 1'b0;   // button wake beats a write of 1
    if (wr_sel) begin
      s3sel_d = wdata_i[B_S3SEL];
      rssel_d = wdata_i[B_RSSEL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      kb_en_q <= 1'b0;
      ms_en_q <= 1'b0;
      pol_q   <= POL_OFF;
      s3sel_q <= 1'b0;
      rssel_q <= 1'b0;
    end else begin
      sleep_q <= sleep_d;
      kb_en_q <= kb_en_d;
      ms_en_q <= ms_en_d;
      pol_q   <= pol_d;
      s3sel_q <= s3sel_d;
      rssel_q <= rssel_d;
    end
  end

  restore_unit u_restore (
    .clk       (clk),
    .rst_n     (rst_n),
    .sb_ok_i   (sb_ok_i),
    .policy_i  (pol_q),
    .wake_i    (pwr_btn_o),
    .sb_rise_o (sb_rise),
    .pwr_on_o  (pwr_on_o)
  );

  w1c_bank #(.W(1)) u_loss (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (sb_rise),
    .clr_wr_i   (wr_ctrl),
    .clr_mask_i (wdata_i[B_LOSS]),
    .flags_o    (loss_flag)
  );

  w1c_bank #(.W(PME_W)) u_pme (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (pme_evt_i),
    .clr_wr_i   (wr_pme),
    .clr_mask_i (wdata_i[PME_W-1:0]),
    .flags_o    (pme_flags)
  );

  assign s1_o      = sleep_q;
  assign s3_o      = s3sel_q ? sleep_q : (s3_pin_i | ~vdd_ok_i);
  assign rst_con_o = rssel_q ? pci_rst_n_i : pwrok_i;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTRL: rdata_o = {loss_flag[0], 2'b00, pol_q, ms_en_q, kb_en_q, sleep_q};
      ADR_SEL:  rdata_o = {6'b0, rssel_q, s3sel_q};
      ADR_PME:  rdata_o = {{(DATA_W-PME_W){1'b0}}, pme_flags};
      default:  rdata_o = '0;
    endcase
  end

  assign unused_wdata = ^wdata_i[6:5];

  p_wake_clears_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_btn_o |=> !sleep_q);

  p_sleep_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_btn_o && !wr_ctrl) |=> $stable(sleep_q));

  p_loss_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sb_rise |=> loss_flag[0]);
endmodule

// File: tb/pwr_restore_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_restore_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sb_ok_i, wr_en_i, btn_i, kb_wake_i, ms_wake_i;
  logic       s3_pin_i, vdd_ok_i, pwrok_i, pci_rst_n_i;
  logic [1:0] addr_i;
  logic [7:0] wdata_i;
  logic [3:0] pme_evt_i;
  logic [7:0] rdata_o;
  logic       pwr_on_o, s1_o, s3_o, rst_con_o, pwr_btn_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic       m_sleep, m_kb, m_ms, m_s3sel, m_rssel, m_loss, m_sbq, m_last, m_on;
  logic [1:0] m_pol;
  logic [3:0] m_pme;

  always #2 clk = ~clk;

  pwr_restore_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sb_ok_i(sb_ok_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pme_evt_i(pme_evt_i), .btn_i(btn_i), .kb_wake_i(kb_wake_i),
    .ms_wake_i(ms_wake_i), .s3_pin_i(s3_pin_i), .vdd_ok_i(vdd_ok_i),
    .pwrok_i(pwrok_i), .pci_rst_n_i(pci_rst_n_i), .pwr_on_o(pwr_on_o),
    .s1_o(s1_o), .s3_o(s3_o), .rst_con_o(rst_con_o), .pwr_btn_o(pwr_btn_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_btn();
    return btn_i | (kb_wake_i & m_kb) | (ms_wake_i & m_ms);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {m_loss, 2'b00, m_pol, m_ms, m_kb, m_sleep};
      2'd1:    return {6'b0, m_rssel, m_s3sel};
      2'd2:    return {4'b0, m_pme};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic restore_val(input logic [1:0] pol, input logic last);
    case (pol)
      2'b00:   return last;
      2'b11:   return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic model_reset();
    m_sleep = 0; m_kb = 0; m_ms = 0; m_s3sel = 0; m_rssel = 0;
    m_loss = 0; m_sbq = 0; m_last = 0; m_on = 0; m_pol = 2'b11; m_pme = 0;
  endtask

  task automatic model_step();
    logic rise, pb, wa, wb, wp, on_n;
    rise = sb_ok_i & ~m_sbq;
    pb   = exp_btn();
    wa   = wr_en_i && addr_i == 2'd0;
    wb   = wr_en_i && addr_i == 2'd1;
    wp   = wr_en_i && addr_i == 2'd2;
    if (!sb_ok_i)  on_n = 1'b0;
    else if (rise) on_n = restore_val(m_pol, m_last);
    else if (pb)   on_n = 1'b1;
    else           on_n = m_on;
    if (sb_ok_i && m_sbq) m_last = m_on;
    m_on  = on_n;
    m_sbq = sb_ok_i;
    if (wa && wdata_i[7]) m_loss = 1'b0;
    if (rise) m_loss = 1'b1;
    m_pme = (m_pme & ~(wp ? wdata_i[3:0] : 4'h0)) | pme_evt_i;
    if (wa) begin
      m_sleep = wdata_i[0]; m_kb = wdata_i[1]; m_ms = wdata_i[2]; m_pol = wdata_i[4:3];
    end
    if (pb) m_sleep = 1'b0;
    if (wb) begin m_s3sel = wdata_i[0]; m_rssel = wdata_i[1]; end
  endtask

  task automatic check_outputs();
    check("R8 pwr_btn_o", {7'b0, pwr_btn_o}, {7'b0, exp_btn()});
    check("R5 s1_o", {7'b0, s1_o}, {7'b0, m_sleep});
    check("R6 s3_o", {7'b0, s3_o}, {7'b0, m_s3sel ? m_sleep : (s3_pin_i | ~vdd_ok_i)});
    check("R7 rst_con_o", {7'b0, rst_con_o}, {7'b0, m_rssel ? pci_rst_n_i : pwrok_i});
    check("R2/R3/R10 pwr_on_o", {7'b0, pwr_on_o}, {7'b0, m_on});
    check("R11/R4/R9 rdata_o", rdata_o, exp_rd(addr_i));
  endtask

  // called at a falling edge with inputs already set
  task automatic run_cycle();
    #1;
    check_outputs();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_en_i = 0; addr_i = 0; wdata_i = 0; pme_evt_i = 0; btn_i = 0;
    kb_wake_i = 0; ms_wake_i = 0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    idle_inputs(); wr_en_i = 1; addr_i = a; wdata_i = d; run_cycle();
    idle_inputs();
  endtask

  task automatic read_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
    idle_inputs(); addr_i = a; #1;
    check(tag, rdata_o, exp);
    run_cycle();
  endtask

  initial begin
    rst_n = 0; sb_ok_i = 0; s3_pin_i = 0; vdd_ok_i = 1; pwrok_i = 1; pci_rst_n_i = 0;
    idle_inputs();
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    check("R1 ctrl reset", rdata_o, 8'h18);
    check("R1 pwr_on reset", {7'b0, pwr_on_o}, 8'h00);
    addr_i = 2'd1; #1; check("R1 sel reset", rdata_o, 8'h00);
    addr_i = 2'd2; #1; check("R1 pme reset", rdata_o, 8'h00);
    addr_i = 2'd0;
    @(negedge clk);
    rst_n = 1;
    run_cycle();

    // R2: standby arrives with default policy off; R4 flag set
    sb_ok_i = 1; run_cycle();
    read_check("R4 loss set on rise", 2'd0, 8'h98);
    check("R2 off policy", {7'b0, pwr_on_o}, 8'h00);

    // R4: write 0 no effect, write 1 clears
    do_write(2'd0, 8'h18); read_check("R4 write0 keeps", 2'd0, 8'h98);
    do_write(2'd0, 8'h98); read_check("R4 write1 clears", 2'd0, 8'h18);

    // R10: button turns power on; then keep-last policy, R3 restore
    btn_i = 1; run_cycle(); idle_inputs(); run_cycle();
    check("R10 button on", {7'b0, pwr_on_o}, 8'h01);
    do_write(2'd0, 8'h00);            // policy keep-last
    sb_ok_i = 0; run_cycle();
    check("R3 off without standby", {7'b0, pwr_on_o}, 8'h00);
    // R4 collision: rise with clearing write in same cycle -> stays set
    sb_ok_i = 1; wr_en_i = 1; addr_i = 0; wdata_i = 8'h80; run_cycle(); idle_inputs();
    check("R3 keep-last restores on", {7'b0, pwr_on_o}, 8'h01);
    read_check("R4 set wins over clear", 2'd0, 8'h80);

    // R2: reserved alias 01 forces on
    do_write(2'd0, 8'h88);
    sb_ok_i = 0; run_cycle(); sb_ok_i = 1; run_cycle();
    check("R2 reserved code on", {7'b0, pwr_on_o}, 8'h01);

    // R5: sleep write, wake vs write-1 collision
    do_write(2'd0, 8'h01);
    check("R5 sleep set", {7'b0, s1_o}, 8'h01);
    repeat (3) run_cycle();
    check("R5 sleep held w/o button", {7'b0, s1_o}, 8'h01);
    wr_en_i = 1; addr_i = 0; wdata_i = 8'h01; btn_i = 1; run_cycle(); idle_inputs();
    check("R5 wake beats write1", {7'b0, s1_o}, 8'h00);

    // R9: PME set wins over clear, write 0 no effect
    pme_evt_i = 4'b0101; run_cycle(); idle_inputs();
    read_check("R9 pme set", 2'd2, 8'h05);
    wr_en_i = 1; addr_i = 2; wdata_i = 8'h05; pme_evt_i = 4'b0001; run_cycle(); idle_inputs();
    read_check("R9 set wins", 2'd2, 8'h01);
    do_write(2'd2, 8'h00); read_check("R9 write0 keeps", 2'd2, 8'h01);

    // constrained random phase against the model
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(39) == 0) sb_ok_i = ~sb_ok_i;
      wr_en_i     = ($urandom_range(3) == 0);
      addr_i      = 2'($urandom_range(3));
      wdata_i     = 8'($urandom);
      pme_evt_i   = ($urandom_range(7) == 0) ? 4'($urandom) : 4'h0;
      btn_i       = ($urandom_range(15) == 0);
      kb_wake_i   = ($urandom_range(7) == 0);
      ms_wake_i   = ($urandom_range(7) == 0);
      s3_pin_i    = 1'($urandom);
      vdd_ok_i    = 1'($urandom);
      pwrok_i     = 1'($urandom);
      pci_rst_n_i = 1'($urandom);
      run_cycle();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule